// File: doc/BRIEF.md
# I2C Target for Register File, Cursor RAM and Colour Table

This block is an I2C target that gives a host on a two-wire bus access to three internal storage areas: a byte-wide control-register file, a 256-byte cursor bitmap RAM and a 256-entry colour look-up table whose entries are 24 bits wide. It takes SCL and SDA through two-flop synchronisers and finds START and STOP conditions as SDA edges while SCL is high. It shifts bytes in on SCL rising edges and changes its own open-drain SDA output only while SCL is low. It answers the 7-bit device address 7'b1000100, which makes 0x88 the write address byte and 0x89 the read address byte.

After the address byte with the write bit, the first byte is a subaddress. Any value except two reserved ones points into the register file, and the data bytes that follow are written at consecutive register addresses. Subaddress 0xFE selects the cursor RAM and 0xFF selects the colour table. In both cases the next byte is a RAM start address and the data bytes after it go to consecutive locations. In the colour table the bytes arrive as red, green, blue triplets. The entry index advances after each blue byte. Writing a new RAM start address resets the component sequence to red. A read first sets the pointer with a write phase, then uses a repeated START and the read address byte. The target then returns bytes from the same area with the same auto-increment, until the host answers a byte with NACK.

The protocol engine uses these states: IDLE, DEVADR (address byte shifting in), DEVACK, SUB, SUBACK, RAMADR, RAMACK, WDATA, WACK, RDATA (byte shifting out), RACK (host acknowledge slot) and IGNORE. The transitions are as follows. DEVADR goes to DEVACK on a match and to IGNORE on a mismatch. DEVACK goes to SUB for a write and to RDATA for a read. SUBACK goes to RAMADR for the two reserved subaddresses and to WDATA otherwise. RAMACK goes to WDATA. WDATA and WACK alternate. RDATA and RACK alternate while the host acknowledges, and a host NACK in RACK leads to IGNORE. A START from any state enters DEVADR, and a STOP from any state enters IDLE. Each state moves forward on the SCL falling edge that closes its byte or acknowledge slot.

Top module: `ctl_i2c_target`

## Requirements
- R1: The target pulls SDA low in the acknowledge slot of an address byte 0x88 or 0x89. For any other address byte it leaves SDA released, and it acknowledges nothing and writes nothing until the next START.
- R2: A write with an ordinary subaddress stores each data byte in the register file and acknowledges it, and the register address increments after every byte.
- R3: The register address wraps from 0xFF to 0x00 during a burst.
- R4: Subaddress 0xFE followed by a start address writes or reads consecutive cursor RAM bytes, and the RAM address wraps from 255 to 0.
- R5: Subaddress 0xFF followed by a start address moves colour-table data as red, green, blue bytes per entry. The entry index advances only after the blue byte.
- R6: Writing a new RAM start address resets the colour component sequence to red.
- R7: After a pointer-setting write, a repeated START and address byte 0x89 make the target return the stored bytes MSB first, advancing the pointer after each byte.
- R8: When the host answers a read byte with NACK, the target releases SDA and drives nothing more until the next START.
- R9: A START or a STOP part-way through a byte aborts it without a write. A START immediately begins a new address phase.
- R10: The target changes its SDA output only while SCL is low.
- R11: During reset the SDA output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls the open-drain SDA line low, 0 releases it |

## Verification
Register bursts are run at a low subaddress and across the 0xFF to 0x00 boundary. This separates a correct increment from a missing one and from a missing wrap. Cursor bursts start at 0xFE and so cross the RAM wrap. Colour-table bursts of two whole triplets show whether the index advances on blue. A partial triplet that is followed by a new start address shows whether the component sequence restarts at red. Negative patterns, namely a foreign address, a host NACK followed by extra clocks, and a START or STOP part-way through a byte, show that the target stays silent and that earlier data survives.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_SUB,
        ST_SUBACK,
        ST_RAMADR,
        ST_RAMACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } fsm_state_t;

    typedef enum logic [1:0] {
        AREA_REG,
        AREA_CUR,
        AREA_LUT
    } area_t;

    localparam logic [1:0] LANE_R = 2'd0;
    localparam logic [1:0] LANE_G = 2'd1;
    localparam logic [1:0] LANE_B = 2'd2;
    localparam int         NUM_LANES = 3;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains, idle-high bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s && !scl_d;
    assign scl_fall  = !scl_s && scl_d;
    // Bus conditions: SDA edge while SCL stays high
    assign start_det = scl_s && scl_d && sda_d && !sda_s;
    assign stop_det  = scl_s && scl_d && !sda_d && sda_s;

endmodule

// File: rtl/i2c_target_store.sv
module i2c_target_store
    import ctl_i2c_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  area_t         wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    wr_lane,
    input  logic [DW-1:0] wr_data,
    input  area_t         rd_sel,
    input  logic [AW-1:0] rd_addr,
    input  logic [1:0]    rd_lane,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] reg_mem [DEPTH];
    logic [DW-1:0] cur_mem [DEPTH];
    logic [DW-1:0] lane_rd [NUM_LANES];

    always_ff @(posedge clk) begin
        if (wr_en && wr_sel == AREA_REG) reg_mem[wr_addr] <= wr_data;
        if (wr_en && wr_sel == AREA_CUR) cur_mem[wr_addr] <= wr_data;
    end

    // One byte-wide array per colour component
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [DW-1:0] lut_mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == AREA_LUT && wr_lane == 2'(g))
                lut_mem[wr_addr] <= wr_data;
        end
        assign lane_rd[g] = lut_mem[rd_addr];
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            AREA_REG: rd_data = reg_mem[rd_addr];
            AREA_CUR: rd_data = cur_mem[rd_addr];
            AREA_LUT: begin
                unique case (rd_lane)
                    LANE_R:  rd_data = lane_rd[0];
                    LANE_G:  rd_data = lane_rd[1];
                    default: rd_data = lane_rd[2];
                endcase
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import ctl_i2c_pkg::*;
#(
    parameter int         AW       = 8,
    parameter logic [6:0] DEV_ADDR = 7'b1000100,
    parameter logic [7:0] SUB_CUR  = 8'hFE,
    parameter logic [7:0] SUB_LUT  = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic          sda_low,
    output logic          wr_en,
    output area_t         wr_sel,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_lane,
    output logic [7:0]    wr_data,
    output area_t         rd_sel,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_lane,
    output fsm_state_t    state,
    output logic [AW-1:0] sub_ptr,
    output logic [AW-1:0] ram_ptr,
    output logic [1:0]    lane,
    output logic          ptr_load
);

    localparam logic [3:0] BYTE_BITS = 4'd8;

    fsm_state_t    state_nx;
    area_t         area;
    logic [7:0]    rx_sr;
    logic [7:0]    tx_sr;
    logic [3:0]    bit_cnt;
    logic          rnw;
    logic          mst_ack;
    logic          byte_end;
    logic [AW-1:0] nxt_sub;
    logic [AW-1:0] nxt_ram;
    logic [1:0]    nxt_lane;

    assign byte_end = scl_fall && (bit_cnt == BYTE_BITS);
    assign rd_sel   = area;
    assign rd_addr  = (area == AREA_REG) ? sub_ptr : ram_ptr;
    assign rd_lane  = lane;

    // Pointer advance after one data byte in the selected area
    always_comb begin
        nxt_sub  = sub_ptr;
        nxt_ram  = ram_ptr;
        nxt_lane = lane;
        unique case (area)
            AREA_REG: nxt_sub = sub_ptr + 1'b1;
            AREA_CUR: nxt_ram = ram_ptr + 1'b1;
            AREA_LUT: begin
                if (lane == LANE_B) begin
                    nxt_lane = LANE_R;
                    nxt_ram  = ram_ptr + 1'b1;
                end else begin
                    nxt_lane = lane + 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = ST_IDLE;
            ST_DEVADR: if (byte_end)
                           state_nx = (rx_sr[7:1] == DEV_ADDR) ? ST_DEVACK : ST_IGNORE;
            ST_DEVACK: if (scl_fall) state_nx = rnw ? ST_RDATA : ST_SUB;
            ST_SUB:    if (byte_end) state_nx = ST_SUBACK;
            ST_SUBACK: if (scl_fall)
                           state_nx = (area == AREA_REG) ? ST_WDATA : ST_RAMADR;
            ST_RAMADR: if (byte_end) state_nx = ST_RAMACK;
            ST_RAMACK: if (scl_fall) state_nx = ST_WDATA;
            ST_WDATA:  if (byte_end) state_nx = ST_WACK;
            ST_WACK:   if (scl_fall) state_nx = ST_WDATA;
            ST_RDATA:  if (byte_end) state_nx = ST_RACK;
            ST_RACK:   if (scl_fall) state_nx = mst_ack ? ST_RDATA : ST_IGNORE;
            ST_IGNORE: state_nx = ST_IGNORE;
            default:   state_nx = ST_IDLE;
        endcase
        if (start_det)     state_nx = ST_DEVADR;
        else if (stop_det) state_nx = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low  <= 1'b0;
            wr_en    <= 1'b0;
            wr_sel   <= AREA_REG;
            wr_addr  <= '0;
            wr_lane  <= LANE_R;
            wr_data  <= '0;
            area     <= AREA_REG;
            sub_ptr  <= '0;
            ram_ptr  <= '0;
            lane     <= LANE_R;
            ptr_load <= 1'b0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            bit_cnt  <= '0;
            rnw      <= 1'b0;
            mst_ack  <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            ptr_load <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVADR, ST_SUB, ST_RAMADR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_end) begin
                            bit_cnt <= '0;
                            if (state == ST_DEVADR) begin
                                rnw     <= rx_sr[0];
                                sda_low <= (rx_sr[7:1] == DEV_ADDR);
                            end else if (state == ST_SUB) begin
                                sda_low <= 1'b1;
                                if (rx_sr == SUB_CUR)      area <= AREA_CUR;
                                else if (rx_sr == SUB_LUT) area <= AREA_LUT;
                                else begin
                                    area    <= AREA_REG;
                                    sub_ptr <= rx_sr[AW-1:0];
                                end
                            end else if (state == ST_RAMADR) begin
                                sda_low  <= 1'b1;
                                ram_ptr  <= rx_sr[AW-1:0];
                                lane     <= LANE_R;
                                ptr_load <= 1'b1;
                            end else begin
                                sda_low <= 1'b1;
                                wr_en   <= 1'b1;
                                wr_sel  <= area;
                                wr_addr <= (area == AREA_REG) ? sub_ptr : ram_ptr;
                                wr_lane <= lane;
                                wr_data <= rx_sr;
                                sub_ptr <= nxt_sub;
                                ram_ptr <= nxt_ram;
                                lane    <= nxt_lane;
                            end
                        end
                    end
                    ST_DEVACK, ST_SUBACK, ST_RAMACK, ST_WACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_DEVACK && rnw) begin
                                tx_sr   <= rd_data;
                                sda_low <= !rd_data[7];
                            end else begin
                                sda_low <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        if (byte_end) begin
                            bit_cnt <= '0;
                            sda_low <= 1'b0;
                            sub_ptr <= nxt_sub;
                            ram_ptr <= nxt_ram;
                            lane    <= nxt_lane;
                        end else if (scl_fall) begin
                            tx_sr   <= {tx_sr[6:0], 1'b0};
                            sda_low <= !tx_sr[6];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mst_ack <= !sda_s;
                        if (scl_fall) begin
                            if (mst_ack) begin
                                tx_sr   <= rd_data;
                                sda_low <= !rd_data[7];
                            end else begin
                                sda_low <= 1'b0;
                            end
                        end
                    end
                    ST_IDLE, ST_IGNORE: sda_low <= 1'b0;
                    default:            sda_low <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
    import ctl_i2c_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1000100,
    parameter logic [7:0] SUB_CUR     = 8'hFE,
    parameter logic [7:0] SUB_LUT     = 8'hFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_low
);

    logic          scl_s;
    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic [7:0]    rd_data;
    logic          wr_en;
    area_t         wr_sel;
    logic [AW-1:0] wr_addr;
    logic [1:0]    wr_lane;
    logic [7:0]    wr_data;
    area_t         rd_sel;
    logic [AW-1:0] rd_addr;
    logic [1:0]    rd_lane;
    fsm_state_t    state;
    logic [AW-1:0] sub_ptr;
    logic [AW-1:0] ram_ptr;
    logic [1:0]    lane;
    logic          ptr_load;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(
        .AW       (AW),
        .DEV_ADDR (DEV_ADDR),
        .SUB_CUR  (SUB_CUR),
        .SUB_LUT  (SUB_LUT)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_low   (sda_pull_low),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_lane   (wr_lane),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_addr   (rd_addr),
        .rd_lane   (rd_lane),
        .state     (state),
        .sub_ptr   (sub_ptr),
        .ram_ptr   (ram_ptr),
        .lane      (lane),
        .ptr_load  (ptr_load)
    );

    i2c_target_store #(.AW(AW), .DW(8)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .wr_lane (wr_lane),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_addr (rd_addr),
        .rd_lane (rd_lane),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/ctl_i2c_target_chk.sv
module ctl_i2c_target_chk
    import ctl_i2c_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_pull_low,
    input logic          scl_s,
    input fsm_state_t    state,
    input logic          wr_en,
    input area_t         wr_sel,
    input logic [AW-1:0] wr_addr,
    input logic [1:0]    wr_lane,
    input logic [AW-1:0] sub_ptr,
    input logic [AW-1:0] ram_ptr,
    input logic [1:0]    lane,
    input logic          ptr_load
);

    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> !scl_s);

    a_r1_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull_low);

    a_r2_reg_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == AREA_REG) |-> sub_ptr == AW'(wr_addr + 1'b1));

    a_r4_cur_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == AREA_CUR) |-> ram_ptr == AW'(wr_addr + 1'b1));

    a_r5_lut_blue_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == AREA_LUT && wr_lane == LANE_B)
            |-> (ram_ptr == AW'(wr_addr + 1'b1)) && (lane == LANE_R));

    a_r5_lut_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == AREA_LUT && wr_lane != LANE_B)
            |-> (ram_ptr == wr_addr) && (lane == 2'(wr_lane + 1'b1)));

    a_r6_new_addr_red: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |-> lane == LANE_R);

endmodule

bind ctl_i2c_target ctl_i2c_target_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_pull_low (sda_pull_low),
    .scl_s        (scl_s),
    .state        (state),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_addr      (wr_addr),
    .wr_lane      (wr_lane),
    .sub_ptr      (sub_ptr),
    .ram_ptr      (ram_ptr),
    .lane         (lane),
    .ptr_load     (ptr_load)
);

// File: tb/ctl_i2c_target_tb_top.sv
`timescale 1ns/1ps
module ctl_i2c_target_tb_top;

    localparam int Q        = 25;
    localparam int WDOG_CYC = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_low;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_byte;
    event       got_ev;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_low;

    ctl_i2c_target dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_pull_low (sda_pull_low)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_slot(input logic v, output logic s);
        tick(4);
        sda_m = v;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        s = sda_bus;
        scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        tick(4);
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(4);
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b1;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
        bit_slot(1'b1, s);
        acked = !s;
    endtask

    task automatic send_ack(input logic [7:0] b, input string tag);
        logic a;
        send_byte(b, a);
        chk(a, tag, a, 1);
    endtask

    task automatic send_nack(input logic [7:0] b, input string tag);
        logic a;
        send_byte(b, a);
        chk(!a, tag, a, 0);
    endtask

    // Driver: push the expected byte, then clock it out of the target
    task automatic rd_byte(input logic [7:0] exp, input bit last, input string tag);
        logic [7:0] b;
        logic s;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            bit_slot(1'b1, s);
            b[i] = s;
        end
        bit_slot(last ? 1'b1 : 1'b0, s);
        got_byte = b;
        ->got_ev;
    endtask

    task automatic rd_setup(input logic [7:0] sub, input bit has_ram, input logic [7:0] ram);
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(sub, "R7");
        if (has_ram) send_ack(ram, "R7");
        i2c_start();
        send_ack(8'h89, "R1");
    endtask

    // Monitor: compare each returned byte with the scoreboard head
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected", int'(got_byte), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got_byte == e, t, int'(got_byte), int'(e));
            end
        end
    end

    // R10: SDA from the target must not move while SCL is high
    logic scl_q = 1'b1;
    logic low_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_q && (sda_pull_low != low_q)) viol++;
        scl_q = scl_m;
        low_q = sda_pull_low;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        tick(WDOG_CYC);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic s;
        int zeros;
        tick(10);
        chk(sda_pull_low == 1'b0, "R11 reset", sda_pull_low, 0);
        rst_n = 1'b1;
        tick(10);

        // R2: register burst, then R7 readback
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'h10, "R2");
        send_ack(8'h11, "R2");
        send_ack(8'h22, "R2");
        send_ack(8'h33, "R2");
        i2c_stop();
        rd_setup(8'h10, 1'b0, 8'h00);
        rd_byte(8'h11, 1'b0, "R7");
        rd_byte(8'h22, 1'b0, "R2");
        rd_byte(8'h33, 1'b1, "R2");
        i2c_stop();

        // R3: register wrap 0xFF -> 0x00
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'hFD, "R3");
        send_ack(8'hA1, "R3");
        send_ack(8'hA2, "R3");
        send_ack(8'hA3, "R3");
        send_ack(8'hA4, "R3");
        i2c_stop();
        rd_setup(8'h00, 1'b0, 8'h00);
        rd_byte(8'hA4, 1'b1, "R3");
        i2c_stop();
        rd_setup(8'hFD, 1'b0, 8'h00);
        rd_byte(8'hA1, 1'b0, "R3");
        rd_byte(8'hA2, 1'b0, "R3");
        rd_byte(8'hA3, 1'b0, "R3");
        rd_byte(8'hA4, 1'b1, "R3");
        i2c_stop();

        // R4: cursor RAM from 0xFE with wrap
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'hFE, "R4");
        send_ack(8'hFE, "R4");
        send_ack(8'hC0, "R4");
        send_ack(8'hC1, "R4");
        send_ack(8'hC2, "R4");
        send_ack(8'hC3, "R4");
        i2c_stop();
        rd_setup(8'hFE, 1'b1, 8'h00);
        rd_byte(8'hC2, 1'b0, "R4");
        rd_byte(8'hC3, 1'b1, "R4");
        i2c_stop();
        rd_setup(8'hFE, 1'b1, 8'hFE);
        rd_byte(8'hC0, 1'b0, "R4");
        rd_byte(8'hC1, 1'b0, "R4");
        rd_byte(8'hC2, 1'b1, "R4");
        i2c_stop();

        // R5: colour table, two triplets
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'hFF, "R5");
        send_ack(8'h05, "R5");
        send_ack(8'h10, "R5");
        send_ack(8'h20, "R5");
        send_ack(8'h30, "R5");
        send_ack(8'h40, "R5");
        send_ack(8'h50, "R5");
        send_ack(8'h60, "R5");
        i2c_stop();
        rd_setup(8'hFF, 1'b1, 8'h06);
        rd_byte(8'h40, 1'b0, "R5");
        rd_byte(8'h50, 1'b0, "R5");
        rd_byte(8'h60, 1'b1, "R5");
        i2c_stop();
        rd_setup(8'hFF, 1'b1, 8'h05);
        rd_byte(8'h10, 1'b0, "R5");
        rd_byte(8'h20, 1'b0, "R5");
        rd_byte(8'h30, 1'b0, "R5");
        rd_byte(8'h40, 1'b1, "R5");
        i2c_stop();

        // R6: partial triplet, then new start address restarts at red
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'hFF, "R6");
        send_ack(8'h07, "R6");
        send_ack(8'h71, "R6");
        send_ack(8'h72, "R6");
        i2c_stop();
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'hFF, "R6");
        send_ack(8'h07, "R6");
        send_ack(8'h91, "R6");
        i2c_stop();
        rd_setup(8'hFF, 1'b1, 8'h07);
        rd_byte(8'h91, 1'b0, "R6");
        rd_byte(8'h72, 1'b1, "R6");
        i2c_stop();

        // R8: host NACK, then extra clocks see a released line
        rd_setup(8'h10, 1'b0, 8'h00);
        rd_byte(8'h11, 1'b1, "R8");
        zeros = 0;
        for (int i = 0; i < 9; i++) begin
            bit_slot(1'b1, s);
            if (!s) zeros++;
        end
        chk(zeros == 0, "R8 released after NACK", zeros, 0);
        i2c_stop();

        // R1: foreign address is ignored until next START
        i2c_start();
        send_nack(8'h90, "R1 foreign address");
        send_nack(8'h10, "R1 ignored byte");
        send_nack(8'hEE, "R1 ignored byte");
        i2c_stop();
        rd_setup(8'h10, 1'b0, 8'h00);
        rd_byte(8'h11, 1'b1, "R1 no write");
        i2c_stop();

        // R9: START part-way through a byte, then STOP part-way
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'h20, "R9");
        bit_slot(1'b1, s);
        bit_slot(1'b0, s);
        bit_slot(1'b1, s);
        i2c_start();
        send_ack(8'h88, "R9 address after START");
        send_ack(8'h20, "R9");
        send_ack(8'h5A, "R9");
        send_ack(8'h3C, "R9");
        i2c_stop();
        i2c_start();
        send_ack(8'h88, "R1");
        send_ack(8'h21, "R9");
        for (int i = 0; i < 4; i++) bit_slot(1'b1, s);
        i2c_stop();
        rd_setup(8'h20, 1'b0, 8'h00);
        rd_byte(8'h5A, 1'b0, "R9");
        rd_byte(8'h3C, 1'b1, "R9 aborted byte");
        i2c_stop();

        tick(10);
        chk(viol == 0, "R10 SDA moved with SCL high", viol, 0);
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule